// File: doc/BRIEF.md
# Crossbar Maximal-Matching Scheduler

This block picks, once per timeslot, which inputs of an N×N input-queued crossbar may send and to which outputs. Every input keeps a separate queue for each output and reports an N-bit occupancy vector. A bit set means that the queue toward that output holds at least one cell, and so that the input requests the output. Because each input can put in a request for every output it has traffic for, a blocked head cell no longer holds back cells behind it for other outputs. This avoids the throughput ceiling of roughly 2−√2 that a single queue per input suffers.

A timeslot begins with a one-cycle `slot_start`. The scheduler captures all request vectors and then runs request/grant/accept rounds, one round per clock. In each round, every output that is still free grants one of the free inputs that request it. Each free input accepts one of the grants it received. Outputs choose with a rotating grant pointer and inputs with a rotating accept pointer. Rounds continue until a round adds no pair or N rounds have run, so the result is a maximal matching. For one cycle at the end of the slot the block then presents a one-hot select per output, a grant row per input and a dequeue strobe per input. The queue storage and the cell data path are outside the block.

The control sequence is a three-state machine. `ST_IDLE` waits. The transition *launch* (IDLE→ITER on `slot_start`) captures the requests and clears the match. `ST_ITER` runs one round per cycle. It stays there on *continue* (the round added a pair and fewer than N rounds have run) and moves on *settle* (ITER→DONE) otherwise. `ST_DONE` presents the result for one cycle and returns on *release* (DONE→IDLE).

Top module: `xbar_sched`

## Requirements
- R1: After reset all outputs are zero, and every grant and accept pointer points at index 0.
- R2: A `slot_start` sampled in ST_IDLE captures `req_vec`. `slot_done` is then high for exactly one cycle, no more than N+1 cycles after the capturing edge. The flat bit index is input*N+output.
- R3: In the result, each output drives at most one bit of its select group `out_sel[o*N +: N]`. Bit i of that group means output o is connected to input i.
- R4: Each input's grant row `in_grant[i*N +: N]` has at most one bit set, with bit o meaning output o. `deq_strobe[i]` is high exactly when that row is non-zero. `out_sel` is the transpose of `in_grant`.
- R5: A pair is granted only if its bit was set in the captured request vector.
- R6: The matching is maximal. No captured request connects an unmatched input to an unmatched output.
- R7: In every round, each free output grants the first free requesting input found by searching upward and wrapping from its grant pointer. Each free input accepts the first granting output found in the same way from its accept pointer.
- R8: Pointers change only for pairs accepted in the first round. The output's grant pointer becomes the accepted input + 1 mod N, and the input's accept pointer becomes the granted output + 1 mod N. Later rounds use the updated pointers.
- R9: While a slot is in progress, `slot_start` and changes on `req_vec` have no effect on the result.
- R10: `in_grant`, `out_sel` and `deq_strobe` are zero in every cycle in which `slot_done` is low.
- R11: Two inputs that keep requesting only the same output are served in alternation on successive slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slot_start | input | 1 | Begin a timeslot; sampled only in ST_IDLE |
| req_vec | input | N*N | Occupancy of the per-output queues, bit input*N+output |
| in_grant | output | N*N | Granted output per input, bit input*N+output, valid in the done cycle |
| out_sel | output | N*N | One-hot crossbar select per output, bit output*N+input |
| deq_strobe | output | N | Pop one cell from the granted queue of this input |
| slot_done | output | 1 | One-cycle marker that the result is valid |

## Verification
Two things can fall in the same cycle: a new `slot_start` and a slot that is still running its rounds or presenting its result. The bench provokes this by holding `slot_start` high and scrambling `req_vec` from the first iteration cycle until the done cycle. It then judges the outcome by comparing the whole result with a bench model fed only the requests captured at launch. The model's pointers must also stay in step on the next slot. A second overlap is the first-round pointer update coinciding with later rounds in the same slot. Full-load and hot-spot sequences expose this, because the later rounds depend on pointers that have just moved.

// File: rtl/xbar_sched_pkg.sv
package xbar_sched_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ITER = 2'd1,
        ST_DONE = 2'd2
    } sched_state_e;

endpackage

// File: rtl/xbar_rr_pick.sv
// Rotating-priority picker: first set bit at or above ptr, wrapping.
module xbar_rr_pick #(
    parameter int N = 4,
    localparam int W = $clog2(N)
) (
    input  logic [N-1:0] cand,
    input  logic [W-1:0] ptr,
    output logic [N-1:0] pick
);

    always_comb begin
        logic found;
        int   idx;
        found = 1'b0;
        pick  = '0;
        for (int k = 0; k < N; k++) begin
            idx = (int'(ptr) + k) % N;
            if (!found && cand[idx]) begin
                pick[idx] = 1'b1;
                found     = 1'b1;
            end
        end
    end

endmodule

// File: rtl/xbar_match_round.sv
// One request/grant/accept round over the free inputs and outputs.
module xbar_match_round #(
    parameter int N = 4,
    localparam int W = $clog2(N)
) (
    input  logic [N*N-1:0] req,      // bit i*N+o
    input  logic [N-1:0]   in_free,
    input  logic [N-1:0]   out_free,
    input  logic [N*W-1:0] gptr_flat,
    input  logic [N*W-1:0] aptr_flat,
    output logic [N*N-1:0] accept    // bit i*N+o
);

    logic [N-1:0] out_gnt [N];  // per output, one-hot over inputs
    logic [N-1:0] in_offer [N]; // per input, grants seen over outputs
    logic [N-1:0] in_acc [N];

    for (genvar o = 0; o < N; o++) begin : g_out
        logic [N-1:0] cand;
        for (genvar i = 0; i < N; i++) begin : g_col
            assign cand[i] = req[i*N+o] & in_free[i] & out_free[o];
        end
        xbar_rr_pick #(.N(N)) u_gpick (
            .cand (cand),
            .ptr  (gptr_flat[o*W +: W]),
            .pick (out_gnt[o])
        );
    end

    for (genvar i = 0; i < N; i++) begin : g_in
        for (genvar o = 0; o < N; o++) begin : g_row
            assign in_offer[i][o]  = out_gnt[o][i];
            assign accept[i*N+o]   = in_acc[i][o];
        end
        xbar_rr_pick #(.N(N)) u_apick (
            .cand (in_offer[i]),
            .ptr  (aptr_flat[i*W +: W]),
            .pick (in_acc[i])
        );
    end

endmodule

// File: rtl/xbar_sched.sv
module xbar_sched
    import xbar_sched_pkg::*;
#(
    parameter int N = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           slot_start,
    input  logic [N*N-1:0] req_vec,
    output logic [N*N-1:0] in_grant,
    output logic [N*N-1:0] out_sel,
    output logic [N-1:0]   deq_strobe,
    output logic           slot_done
);

    localparam int W  = $clog2(N);
    localparam int CW = W + 1;

    sched_state_e   state_q, state_d;
    logic [N*N-1:0] req_q;
    logic [N*N-1:0] match_q;
    logic [CW-1:0]  round_q;
    logic [W-1:0]   gptr_q [N];
    logic [W-1:0]   aptr_q [N];
    logic [W-1:0]   gptr_d [N];
    logic [W-1:0]   aptr_d [N];
    logic [N*W-1:0] gptr_flat, aptr_flat;
    logic [N-1:0]   in_free, out_free;
    logic [N*N-1:0] accept;
    logic           round_empty, round_last, first_round;

    // free maps and flattened pointers
    for (genvar i = 0; i < N; i++) begin : g_free_in
        assign in_free[i]          = ~|match_q[i*N +: N];
        assign gptr_flat[i*W +: W] = gptr_q[i];
        assign aptr_flat[i*W +: W] = aptr_q[i];
    end
    for (genvar o = 0; o < N; o++) begin : g_free_out
        logic [N-1:0] col;
        for (genvar i = 0; i < N; i++) begin : g_c
            assign col[i] = match_q[i*N+o];
        end
        assign out_free[o] = ~|col;
    end

    xbar_match_round #(.N(N)) u_round (
        .req       (req_q),
        .in_free   (in_free),
        .out_free  (out_free),
        .gptr_flat (gptr_flat),
        .aptr_flat (aptr_flat),
        .accept    (accept)
    );

    assign round_empty = ~|accept;
    assign round_last  = (round_q == CW'(N-1));
    assign first_round = (round_q == '0);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (slot_start) state_d = ST_ITER;                 // launch
            ST_ITER: if (round_empty || round_last) state_d = ST_DONE;  // settle
            ST_DONE: state_d = ST_IDLE;                                 // release
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // first-round pointer moves
    always_comb begin
        for (int o = 0; o < N; o++) begin
            gptr_d[o] = gptr_q[o];
            for (int i = 0; i < N; i++) begin
                if (accept[i*N+o]) gptr_d[o] = W'((i + 1) % N);
            end
        end
        for (int i = 0; i < N; i++) begin
            aptr_d[i] = aptr_q[i];
            for (int o = 0; o < N; o++) begin
                if (accept[i*N+o]) aptr_d[i] = W'((o + 1) % N);
            end
        end
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q   <= '0;
            match_q <= '0;
            round_q <= '0;
            for (int k = 0; k < N; k++) begin
                gptr_q[k] <= '0;
                aptr_q[k] <= '0;
            end
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (slot_start) begin
                        req_q   <= req_vec;
                        match_q <= '0;
                        round_q <= '0;
                    end
                end
                ST_ITER: begin
                    match_q <= match_q | accept;
                    round_q <= round_q + CW'(1);
                    if (first_round) begin
                        for (int k = 0; k < N; k++) begin
                            gptr_q[k] <= gptr_d[k];
                            aptr_q[k] <= aptr_d[k];
                        end
                    end
                end
                ST_DONE: ;
                default: ;
            endcase
        end
    end

    // output process
    always_comb begin
        in_grant   = '0;
        out_sel    = '0;
        deq_strobe = '0;
        slot_done  = 1'b0;
        unique case (state_q)
            ST_DONE: begin
                slot_done = 1'b1;
                in_grant  = match_q;
                for (int i = 0; i < N; i++) begin
                    deq_strobe[i] = |match_q[i*N +: N];
                    for (int o = 0; o < N; o++) begin
                        out_sel[o*N+i] = match_q[i*N+o];
                    end
                end
            end
            ST_IDLE, ST_ITER: ;
            default: ;
        endcase
    end

endmodule

// File: rtl/xbar_sched_chk.sv
module xbar_sched_chk #(
    parameter int N = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           slot_start,
    input logic [N*N-1:0] req_q,
    input logic [N*N-1:0] in_grant,
    input logic [N*N-1:0] out_sel,
    input logic [N-1:0]   deq_strobe,
    input logic           slot_done
);

    logic busy_c;
    int   age_c;
    logic max_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_c <= 1'b0;
            age_c  <= 0;
        end else if (slot_done) begin
            busy_c <= 1'b0;
            age_c  <= 0;
        end else if (slot_start && !busy_c) begin
            busy_c <= 1'b1;
            age_c  <= 1;
        end else if (busy_c) begin
            age_c  <= age_c + 1;
        end
    end

    always_comb begin
        max_ok = 1'b1;
        for (int i = 0; i < N; i++) begin
            for (int o = 0; o < N; o++) begin
                if (req_q[i*N+o] && !(|in_grant[i*N +: N])) begin
                    for (int j = 0; j < N; j++) begin
                        if (out_sel[o*N+j]) continue;
                    end
                    if (!(|out_sel[o*N +: N])) max_ok = 1'b0;
                end
            end
        end
    end

    for (genvar k = 0; k < N; k++) begin : g_k
        assert_sel_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(out_sel[k*N +: N]));
        assert_grant_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(in_grant[k*N +: N]));
        assert_deq_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
            deq_strobe[k] == (|in_grant[k*N +: N]));
    end

    assert_grant_requested_R5: assert property (@(posedge clk) disable iff (!rst_n)
        slot_done |-> ((in_grant & ~req_q) == '0));
    assert_maximal_R6: assert property (@(posedge clk) disable iff (!rst_n)
        slot_done |-> max_ok);
    assert_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_done |-> (in_grant == '0 && out_sel == '0 && deq_strobe == '0));
    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        slot_done |=> !slot_done);
    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy_c |-> (age_c <= N + 1));
    assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_c && $past(busy_c)) |-> $stable(req_q));

endmodule

bind xbar_sched xbar_sched_chk #(.N(N)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .slot_start (slot_start),
    .req_q      (req_q),
    .in_grant   (in_grant),
    .out_sel    (out_sel),
    .deq_strobe (deq_strobe),
    .slot_done  (slot_done)
);

// File: tb/xbar_sched_test.sv
module xbar_sched_test;

    localparam int N       = 4;
    localparam int CLK_PER = 10;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           slot_start = 1'b0;
    logic [N*N-1:0] req_vec = '0;
    logic [N*N-1:0] in_grant, out_sel;
    logic [N-1:0]   deq_strobe;
    logic           slot_done;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int gp [N];
    int ap [N];

    always #(CLK_PER/2) clk = ~clk;

    xbar_sched #(.N(N)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .slot_start (slot_start),
        .req_vec    (req_vec),
        .in_grant   (in_grant),
        .out_sel    (out_sel),
        .deq_strobe (deq_strobe),
        .slot_done  (slot_done)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            fails++;
            $display("FAIL watchdog: actual cycle %0d expected < 100000", cyc);
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Reference: R7/R8 rounds, pointers updated after round 0
    function automatic logic [N*N-1:0] model(input logic [N*N-1:0] r);
        logic [N*N-1:0] m;
        logic [N-1:0]   ifr, ofr;
        int             g [N];
        int             ng [N];
        int             na [N];
        m = '0; ifr = '1; ofr = '1;
        for (int it = 0; it < N; it++) begin
            for (int o = 0; o < N; o++) begin
                g[o] = -1;
                ng[o] = gp[o];
                na[o] = ap[o];
                if (ofr[o]) begin
                    for (int k = 0; k < N; k++) begin
                        int i;
                        i = (gp[o] + k) % N;
                        if (g[o] < 0 && ifr[i] && r[i*N+o]) g[o] = i;
                    end
                end
            end
            for (int i = 0; i < N; i++) begin
                if (ifr[i]) begin
                    int sel;
                    sel = -1;
                    for (int k = 0; k < N; k++) begin
                        int o;
                        o = (ap[i] + k) % N;
                        if (sel < 0 && g[o] == i) sel = o;
                    end
                    if (sel >= 0) begin
                        m[i*N+sel] = 1'b1;
                        ifr[i] = 1'b0;
                        ofr[sel] = 1'b0;
                        ng[sel] = (i + 1) % N;
                        na[i] = (sel + 1) % N;
                    end
                end
            end
            if (it == 0) begin
                for (int k = 0; k < N; k++) begin
                    gp[k] = ng[k];
                    ap[k] = na[k];
                end
            end
        end
        return m;
    endfunction

    function automatic logic [N*N-1:0] transpose(input logic [N*N-1:0] m);
        logic [N*N-1:0] t;
        for (int i = 0; i < N; i++)
            for (int o = 0; o < N; o++)
                t[o*N+i] = m[i*N+o];
        return t;
    endfunction

    // Run one slot; if disturb, hold slot_start and scramble req_vec mid-slot (R9)
    task automatic run_slot(input logic [N*N-1:0] r, input bit disturb,
                            output logic [N*N-1:0] got);
        logic [N*N-1:0] exp;
        logic [N-1:0]   dq;
        int             lat;
        bit             seen;
        exp = model(r);
        for (int i = 0; i < N; i++) dq[i] = |exp[i*N +: N];
        @(negedge clk);
        req_vec    = r;
        slot_start = 1'b1;
        @(negedge clk);
        slot_start = disturb;
        if (disturb) req_vec = N*N'($urandom);
        seen = 0; lat = 0;
        for (int c = 1; c <= N + 3 && !seen; c++) begin
            if (slot_done) begin
                seen = 1; lat = c;
            end else begin
                chk("R10 quiet", {in_grant, out_sel, deq_strobe}, '0);
                @(negedge clk);
                if (disturb) req_vec = N*N'($urandom);
            end
        end
        slot_start = 1'b0;
        chk("R2 done seen", 64'(seen), 64'd1);
        chk("R2 latency bound", 64'(lat <= N + 1), 64'd1);
        chk(disturb ? "R9 R7 grant" : "R7 R5 R6 grant", 64'(in_grant), 64'(exp));
        chk("R3 R4 select", 64'(out_sel), 64'(transpose(exp)));
        chk("R4 dequeue", 64'(deq_strobe), 64'(dq));
        got = in_grant;
        @(negedge clk);
        chk("R2 done one cycle", 64'(slot_done), 64'd0);
    endtask

    initial begin
        logic [N*N-1:0] got;
        logic [N*N-1:0] prev;
        void'($urandom(32'd20250611));
        for (int k = 0; k < N; k++) begin gp[k] = 0; ap[k] = 0; end
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 reset outputs", {in_grant, out_sel, deq_strobe, slot_done}, '0);
        rst_n = 1'b1;
        // R1: first full-load slot from zero pointers gives input0->output0
        run_slot('1, 0, got);
        chk("R1 zero pointers", 64'(got[0]), 64'd1);
        // empty requests
        run_slot('0, 0, got);
        chk("R6 empty", 64'(got), 64'd0);
        // R8: sustained full load
        for (int s = 0; s < 6; s++) run_slot('1, 0, got);
        // R11: inputs 0 and 1 only want output 0; must alternate
        prev = '0;
        for (int s = 0; s < 6; s++) begin
            run_slot(16'h0011, 0, got);
            if (s > 0) chk("R11 alternation", 64'(got != prev), 64'd1);
            prev = got;
        end
        // diagonal and anti-diagonal
        run_slot(16'h8421, 0, got);
        run_slot(16'h1248, 0, got);
        // R9: restart and request changes during a slot
        for (int s = 0; s < 4; s++) run_slot(N*N'($urandom), 1, got);
        run_slot('1, 0, got);
        // random traffic
        for (int s = 0; s < 300; s++) begin
            logic [N*N-1:0] r;
            r = N*N'($urandom);
            if (s % 5 == 0) r = r & N*N'($urandom);
            run_slot(r, (s % 17) == 3, got);
        end
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule